// File: doc/BRIEF.md
# Serial EEPROM SPI Slave Controller

This block is the slave-side protocol engine of a byte-wide serial EEPROM on an SPI bus. It runs on a fast system clock and oversamples the bus pins: chip select, serial clock, serial data in and a pause input. It drives the serial data out pin together with an output enable that stands for high impedance. It collects an 8-bit opcode, a two-byte address and data bytes, always most significant bit first. It serves sequential array reads through a combinational read port and status register reads. Array writes are held in a 32-byte page latch inside the block, and status register writes wait in a pending register.

Nothing reaches the array or the status bits until chip select rises after a complete, byte-aligned and permitted write sequence. At that point a single pulse tells the companion block to start its self-timed write cycle. A sequencer then pushes the latched bytes to the array write port, one entry per clock. The companion block also decides page protection and status-write locking, and it reports whether a write cycle is running.

Top module: `spimem_ctrl`

## Requirements
- R1: After reset so_en_o, wr_en_o and cycle_start_o are low, prot_cfg_o is 0, and a status read returns 0x00.
- R2: so_en_o is low while chip select is high, and high while read data is being shifted out with chip select low and no pause.
- R3: Opcode 0x06 sets the write enable latch and 0x04 clears it. Opcode 0x05 shifts out the status byte, which holds protect-enable in bit 7, the two block bits in bits 3:2, the write enable latch in bit 1 and write-in-progress in bit 0. The status byte repeats for as long as clocking continues.
- R4: Opcode 0x03 followed by two address bytes returns array data MSB first. Bits are sampled on SCK rising edges and the output changes after falling edges. The upper 4 address bits are ignored.
- R5: A read keeps advancing through consecutive addresses, and after 0xFFF it continues at 0x000.
- R6: Opcode 0x02 stages its data bytes without touching the array. On the chip-select rise that ends a valid sequence, cycle_start_o pulses once and each staged byte is written exactly once to its address.
- R7: Write bytes past the end of a 32-byte page wrap to the start of the same page. Other bytes of the page keep their contents.
- R8: A write or status write is discarded when chip select rises with a partial byte shifted in. The write enable latch is left unchanged.
- R9: A write or status write only takes effect when the write enable latch is set. A committed one clears the latch.
- R10: A write is discarded when prot_page_i is high at the closing chip-select rise. A status write is discarded when sr_lock_i is high at that rise.
- R11: Opcode 0x01 followed by a data byte loads protect-enable from bit 7 and the block bits from bits 3:2 at the closing chip-select rise, shown on prot_cfg_o as {enable, block[1:0]}.
- R12: While hold_ni is low with chip select low, SCK and SI are ignored and so_en_o is low. After release, the transfer continues from the exact bit where it paused.
- R13: While busy_i is high, the write-in-progress bit reads 1 and every opcode except the status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversampling the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 or 3 |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause input, active low |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output enable for so_o; low means high impedance |
| rd_addr_o | output | 12 | Array read address |
| rd_data_i | input | 8 | Array read data, combinational from rd_addr_o |
| wr_en_o | output | 1 | Array write strobe from the commit sequencer |
| wr_addr_o | output | 12 | Array write address |
| wr_data_o | output | 8 | Array write data |
| cycle_start_o | output | 1 | One-clock pulse starting the self-timed write cycle |
| busy_i | input | 1 | Write cycle in progress, from the companion timer |
| prot_page_i | input | 1 | Target page is write protected |
| sr_lock_i | input | 1 | Status register writes are hardware locked |
| wr_page_o | output | 7 | Page number of the current write, for the protection decision |
| prot_cfg_o | output | 3 | Stored {protect-enable, block[1:0]} |

## Verification
The hardest state to reach from the ports is a pause in the middle of a read data byte. The bench shifts out three bits of the second byte and then drops hold_ni. While the pause is active it toggles SCK and SI several times, then releases the pause and clocks the remaining five bits. The byte it rebuilds must match the expected data, and the next byte must come from the following address. Writes that cross a page boundary, and writes cut off a few bits into a byte, are driven the same way through the bus pins. In both cases the array write port is compared on every clock against the writes the bench model predicts.

// File: rtl/spimem_pkg.sv
`timescale 1ns/1ps
package spimem_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_e;
  typedef enum logic [2:0] {OP_NONE, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE} op_e;

  localparam logic [7:0] OPC_WEL_SET = 8'h06;
  localparam logic [7:0] OPC_WEL_CLR = 8'h04;
  localparam logic [7:0] OPC_SR_RD   = 8'h05;
  localparam logic [7:0] OPC_SR_WR   = 8'h01;
  localparam logic [7:0] OPC_ARR_RD  = 8'h03;
  localparam logic [7:0] OPC_ARR_WR  = 8'h02;
endpackage

// File: rtl/spimem_sync.sv
`timescale 1ns/1ps
module spimem_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spimem_page_latch.sv
`timescale 1ns/1ps
module spimem_page_latch #(
  parameter int unsigned AW     = 12,
  parameter int unsigned PAGE_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 st_we_i,
  input  logic [PAGE_W-1:0]    st_idx_i,
  input  logic [7:0]           st_data_i,
  input  logic                 clr_i,
  input  logic                 commit_i,
  input  logic [AW-PAGE_W-1:0] page_i,
  output logic                 wr_en_o,
  output logic [AW-1:0]        wr_addr_o,
  output logic [7:0]           wr_data_o,
  output logic                 busy_o,
  output logic                 any_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;
  localparam logic [PAGE_W-1:0] LAST = PAGE_W'(DEPTH - 1);

  logic [7:0]           lat_q [DEPTH];
  logic [DEPTH-1:0]     vld_q;
  logic                 busy_q;
  logic [PAGE_W-1:0]    idx_q;
  logic [AW-PAGE_W-1:0] page_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (st_we_i && !busy_q && st_idx_i == PAGE_W'(g)) lat_q[g] <= st_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= '0;
      busy_q    <= 1'b0;
      idx_q     <= '0;
      page_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      if (commit_i && !busy_q) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        page_q <= page_i;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          vld_q  <= '0;
        end
      end else if (clr_i) begin
        vld_q <= '0;
      end else if (st_we_i) begin
        vld_q[st_idx_i] <= 1'b1;
      end
      // one entry per clock, skipped when never loaded
      wr_en_o   <= busy_q & vld_q[idx_q];
      wr_addr_o <= {page_q, idx_q};
      wr_data_o <= lat_q[idx_q];
    end
  end

  assign busy_o = busy_q | wr_en_o;
  assign any_o  = |vld_q;
endmodule

// File: rtl/spimem_ctrl.sv
`timescale 1ns/1ps
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter int unsigned PAGE_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 sck_i,
  input  logic                 si_i,
  input  logic                 hold_ni,
  output logic                 so_o,
  output logic                 so_en_o,
  output logic [AW-1:0]        rd_addr_o,
  input  logic [7:0]           rd_data_i,
  output logic                 wr_en_o,
  output logic [AW-1:0]        wr_addr_o,
  output logic [7:0]           wr_data_o,
  output logic                 cycle_start_o,
  input  logic                 busy_i,
  input  logic                 prot_page_i,
  input  logic                 sr_lock_i,
  output logic [AW-PAGE_W-1:0] wr_page_o,
  output logic [2:0]           prot_cfg_o
);
  localparam int unsigned AHI_W = AW - 8;

  logic [3:0] pins_s;
  logic cs_act, hold_act, si_s, sck_s;

  spimem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b1100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, hold_ni, si_i, sck_i}),
    .q_o    (pins_s)
  );
  assign cs_act   = ~pins_s[3];
  assign hold_act = ~pins_s[2];
  assign si_s     = pins_s[1];
  assign sck_s    = pins_s[0];

  phase_e            phase_q;
  op_e               op_q;
  logic [2:0]        bit_q;
  logic              abyte_q;
  logic [6:0]        shin_q;
  logic [AHI_W-1:0]  ahi_q;
  logic [AW-1:0]     addr_q;
  logic              wel_q, wpen_q;
  logic [1:0]        bp_q;
  logic [2:0]        sr_pend_q;
  logic              sr_have_q;
  logic [7:0]        out_q;
  logic              load_q, out_on_q;
  logic              sck_prev_q, cs_prev_q;

  logic rise, fall, cs_end, byte_done, wip, lat_busy, lat_any;
  logic st_we, seq_ok, wr_go, sr_go;
  logic [7:0] byte_in, status;

  assign rise      = sck_s & ~sck_prev_q & cs_act & ~hold_act;
  assign fall      = ~sck_s & sck_prev_q & cs_act & ~hold_act;
  assign cs_end    = cs_prev_q & ~cs_act;
  assign byte_in   = {shin_q, si_s};
  assign byte_done = rise && bit_q == 3'd7;
  assign wip       = busy_i | lat_busy;
  assign status    = {wpen_q, 3'b000, bp_q, wel_q, wip};

  assign st_we  = byte_done && phase_q == PH_DATA && op_q == OP_WRITE;
  assign seq_ok = phase_q == PH_DATA && bit_q == 3'd0 && wel_q && !wip;
  assign wr_go  = seq_ok && op_q == OP_WRITE && lat_any && !prot_page_i;
  assign sr_go  = seq_ok && op_q == OP_WRSR && sr_have_q && !sr_lock_i;

  spimem_page_latch #(.AW(AW), .PAGE_W(PAGE_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_we_i   (st_we),
    .st_idx_i  (addr_q[PAGE_W-1:0]),
    .st_data_i (byte_in),
    .clr_i     (cs_end & ~wr_go),
    .commit_i  (cs_end & wr_go),
    .page_i    (addr_q[AW-1:PAGE_W]),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .busy_o    (lat_busy),
    .any_o     (lat_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;   op_q <= OP_NONE;
      bit_q <= '0;         abyte_q <= 1'b0;
      shin_q <= '0;        ahi_q <= '0;       addr_q <= '0;
      wel_q <= 1'b0;       wpen_q <= 1'b0;    bp_q <= '0;
      sr_pend_q <= '0;     sr_have_q <= 1'b0;
      out_q <= '0;         load_q <= 1'b0;    out_on_q <= 1'b0;
      sck_prev_q <= 1'b0;  cs_prev_q <= 1'b0;
      so_en_o <= 1'b0;     cycle_start_o <= 1'b0;
    end else begin
      sck_prev_q    <= sck_s;
      cs_prev_q     <= cs_act;
      cycle_start_o <= 1'b0;
      so_en_o       <= cs_act & ~hold_act & out_on_q;
      if (!cs_act) begin
        phase_q <= PH_CMD;  op_q <= OP_NONE;  bit_q <= '0;  abyte_q <= 1'b0;
        load_q <= 1'b0;     out_on_q <= 1'b0; sr_have_q <= 1'b0;
        if (cs_end && wr_go) begin
          wel_q <= 1'b0;
          cycle_start_o <= 1'b1;
        end
        if (cs_end && sr_go) begin
          {wpen_q, bp_q} <= sr_pend_q;
          wel_q <= 1'b0;
          cycle_start_o <= 1'b1;
        end
      end else begin
        if (rise) begin
          shin_q <= byte_in[6:0];
          bit_q  <= bit_q + 1'b1;
        end
        if (byte_done) begin
          unique case (phase_q)
            PH_CMD: begin
              phase_q <= PH_SKIP;
              if (byte_in == OPC_SR_RD) begin
                op_q <= OP_RDSR;  phase_q <= PH_DATA;  load_q <= 1'b1;
              end else if (!wip) begin
                unique case (byte_in)
                  OPC_WEL_SET: wel_q <= 1'b1;
                  OPC_WEL_CLR: wel_q <= 1'b0;
                  OPC_SR_WR:   begin op_q <= OP_WRSR;  phase_q <= PH_DATA; end
                  OPC_ARR_RD:  begin op_q <= OP_READ;  phase_q <= PH_ADDR; end
                  OPC_ARR_WR:  begin op_q <= OP_WRITE; phase_q <= PH_ADDR; end
                  default: ;
                endcase
              end
            end
            PH_ADDR: begin
              abyte_q <= 1'b1;
              if (!abyte_q) ahi_q <= byte_in[AHI_W-1:0];
              else begin
                addr_q  <= {ahi_q, byte_in};
                phase_q <= PH_DATA;
                load_q  <= (op_q == OP_READ);
              end
            end
            PH_DATA: begin
              unique case (op_q)
                OP_READ:  begin addr_q <= addr_q + 1'b1; load_q <= 1'b1; end
                OP_RDSR:  load_q <= 1'b1;
                OP_WRITE: addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                OP_WRSR:  begin sr_pend_q <= {byte_in[7], byte_in[3:2]}; sr_have_q <= 1'b1; end
                default: ;
              endcase
            end
            default: ;
          endcase
        end
        if (fall) begin
          if (load_q) begin
            out_q    <= (op_q == OP_RDSR) ? status : rd_data_i;
            load_q   <= 1'b0;
            out_on_q <= 1'b1;
          end else begin
            out_q <= {out_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign so_o       = out_q[7];
  assign rd_addr_o  = addr_q;
  assign wr_page_o  = addr_q[AW-1:PAGE_W];
  assign prot_cfg_o = {wpen_q, bp_q};
endmodule

// File: rtl/spimem_ctrl_chk.sv
`timescale 1ns/1ps
module spimem_ctrl_chk #(
  parameter int unsigned AW     = 12,
  parameter int unsigned PAGE_W = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_act_i,
  input logic          hold_act_i,
  input logic          so_en_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic          cyc_i,
  input logic          busy_i,
  input logic          wel_i
);
  // R2
  so_cs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !so_en_i);

  // R12
  so_hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act_i |=> !so_en_i);

  // R6
  commit_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i |-> !cs_act_i);

  // R13
  commit_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i |-> !$past(busy_i));

  // R9
  wel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i |-> !wel_i);

  // R7
  page_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && $past(wr_en_i)) |->
      (wr_addr_i[AW-1:PAGE_W] == $past(wr_addr_i[AW-1:PAGE_W]) &&
       wr_addr_i[PAGE_W-1:0] == $past(wr_addr_i[PAGE_W-1:0]) + 1'b1));
endmodule

bind spimem_ctrl spimem_ctrl_chk #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act_i   (cs_act),
  .hold_act_i (hold_act),
  .so_en_i    (so_en_o),
  .wr_en_i    (wr_en_o),
  .wr_addr_i  (wr_addr_o),
  .cyc_i      (cycle_start_o),
  .busy_i     (busy_i),
  .wel_i      (wel_q)
);

// File: tb/spimem_ctrl_test.sv
`timescale 1ns/1ps
module spimem_ctrl_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic busy = 1'b0, prot = 1'b0, lock = 1'b0;
  logic so, so_en, wr_en, cyc;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [6:0] wr_page;
  logic [2:0] cfg;

  logic [7:0] mem [4096];
  logic [7:0] ref_mem [4096];
  bit         exp_v [4096];
  logic [7:0] exp_d [4096];
  int exp_cnt = 0, stray = 0, wr_seen = 0, cyc_cnt = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spimem_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_en_o(so_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .cycle_start_o(cyc), .busy_i(busy),
    .prot_page_i(prot), .sr_lock_i(lock), .wr_page_o(wr_page),
    .prot_cfg_o(cfg)
  );

  assign rd_data = mem[rd_addr];

  // per-clock comparison of the array write port against the model
  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        wr_seen++;
        if (exp_v[wr_addr] && exp_d[wr_addr] == wr_data) begin
          exp_v[wr_addr] = 1'b0;
          exp_cnt--;
        end else stray++;
        mem[wr_addr] <= wr_data;
      end
      if (cyc) cyc_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    @(negedge clk) si = b;
    ticks(HALF);
    r = so;
    sck = 1'b1;
    ticks(HALF);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    ticks(HALF);
  endtask

  task automatic cs_hi();
    @(negedge clk) cs_n = 1'b1;
    ticks(60);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xbyte(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, d);
      chk(req, d, ref_mem[(int'(a) + i) & 12'hFFF]);
      if (i == 0) chk("R2 so driven during read", so_en, 1);
    end
    cs_hi();
  endtask

  task automatic wr_seq(input logic [15:0] a, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3, input int n, input bit ok);
    logic [7:0] d;
    logic [7:0] bs [4];
    int base, off, seen0;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    base = int'(a) & 12'hFE0;
    off  = int'(a) & 31;
    seen0 = wr_seen;
    cs_lo();
    xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      xbyte(bs[i], d);
      if (ok) begin
        if (!exp_v[base + off]) exp_cnt++;
        exp_v[base + off] = 1'b1;
        exp_d[base + off] = bs[i];
        ref_mem[base + off] = bs[i];
      end
      off = (off + 1) & 31;
    end
    ticks(10);
    chk("R6 nothing written before chip select rises", wr_seen - seen0, 0);
    cs_hi();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] s, d, rb;
    logic r;
    int c0;
    for (int a = 0; a < 4096; a++) begin
      mem[a] = 8'((a * 7 + 3) ^ (a >> 4));
      ref_mem[a] = mem[a];
      exp_v[a] = 1'b0;
      exp_d[a] = 8'h00;
    end
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    chk("R1 so_en after reset", so_en, 0);
    chk("R1 wr_en after reset", wr_en, 0);
    chk("R1 cycle_start after reset", cyc, 0);
    chk("R1 prot_cfg after reset", cfg, 0);
    rdsr(s); chk("R1 status after reset", s, 8'h00);
    chk("R2 so released with cs high", so_en, 0);

    rd_chk("R4 read with upper address bits ignored", 16'hF123, 3);
    rd_chk("R5 read wraps past 0xFFF", 16'h0FFE, 4);

    cmd(8'h06); rdsr(s); chk("R3 WREN sets latch", s, 8'h02);
    cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, rb); cs_hi();
    chk("R3 status repeats first", s, 8'h02);
    chk("R3 status repeats second", rb, 8'h02);
    cmd(8'h04); rdsr(s); chk("R3 WRDI clears latch", s, 8'h00);

    c0 = cyc_cnt;
    wr_seq(16'h0040, 8'h11, 8'h22, 8'h00, 8'h00, 2, 0);
    chk("R9 write without latch leaves array", mem[12'h040], ref_mem[12'h040]);
    chk("R9 no cycle start without latch", cyc_cnt - c0, 0);

    cmd(8'h06);
    c0 = cyc_cnt;
    wr_seq(16'h005E, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 4, 1);
    chk("R6 one cycle start pulse", cyc_cnt - c0, 1);
    chk("R6 byte at 0x05E", mem[12'h05E], 8'hA1);
    chk("R7 wrap byte at 0x040", mem[12'h040], 8'hC3);
    chk("R7 wrap byte at 0x041", mem[12'h041], 8'hD4);
    chk("R7 rest of page kept", mem[12'h042], ref_mem[12'h042]);
    chk("R7 next page untouched", mem[12'h060], ref_mem[12'h060]);
    rdsr(s); chk("R9 latch cleared by write", s, 8'h00);
    rd_chk("R6 committed data reads back", 16'h005E, 4);

    cmd(8'h06);
    c0 = cyc_cnt;
    cs_lo();
    xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h00, d); xbyte(8'h5A, d);
    for (int i = 0; i < 3; i++) xbit(1'b1, r);
    cs_hi();
    chk("R8 partial byte discards write", mem[12'h100], ref_mem[12'h100]);
    chk("R8 no cycle start on partial byte", cyc_cnt - c0, 0);
    rdsr(s); chk("R8 latch kept after discard", s, 8'h02);

    prot = 1'b1;
    wr_seq(16'h0200, 8'h77, 8'h00, 8'h00, 8'h00, 1, 0);
    prot = 1'b0;
    chk("R10 protected page unchanged", mem[12'h200], ref_mem[12'h200]);
    rdsr(s); chk("R10 latch kept after protected write", s, 8'h02);
    lock = 1'b1;
    cs_lo(); xbyte(8'h01, d); xbyte(8'h8C, d); cs_hi();
    lock = 1'b0;
    chk("R10 locked status write discarded", cfg, 0);
    c0 = cyc_cnt;
    cs_lo(); xbyte(8'h01, d); xbyte(8'h8C, d); cs_hi();
    chk("R11 status write loads config", cfg, 3'b111);
    chk("R11 status write starts cycle", cyc_cnt - c0, 1);
    rdsr(s); chk("R11 status read after write", s, 8'h8C);

    busy = 1'b1;
    ticks(2);
    rdsr(s); chk("R13 busy shows in status", s, 8'h8D);
    cmd(8'h06);
    rdsr(s); chk("R13 WREN ignored while busy", s, 8'h8D);
    busy = 1'b0;
    ticks(2);
    rdsr(s); chk("R13 busy cleared", s, 8'h8C);

    cs_lo();
    xbyte(8'h03, d); xbyte(8'h03, d); xbyte(8'h00, d);
    xbyte(8'h00, d); chk("R12 byte before pause", d, ref_mem[12'h300]);
    for (int i = 7; i >= 5; i--) begin xbit(1'b0, r); rb[i] = r; end
    chk("R2 so driven mid byte", so_en, 1);
    @(negedge clk) hold_n = 1'b0;
    ticks(4);
    chk("R12 so released during pause", so_en, 0);
    for (int i = 0; i < 4; i++) xbit(1'b1, r);
    @(negedge clk) hold_n = 1'b1;
    ticks(HALF);
    for (int i = 4; i >= 0; i--) begin xbit(1'b0, r); rb[i] = r; end
    chk("R12 byte resumed after pause", rb, ref_mem[12'h301]);
    xbyte(8'h00, d); chk("R12 address not advanced by pause", d, ref_mem[12'h302]);
    cs_hi();
    chk("R2 so released after read", so_en, 0);

    chk("R6 all expected writes seen", exp_cnt, 0);
    chk("R8 no unexpected array writes", stray, 0);
    summary();
  end
endmodule